// File: doc/BRIEF.md
# Paced Buffer-to-Sink Byte Streamer

This block moves bytes out of a local buffer memory toward an external byte sink at a steady rate. Software first programs a 16-bit byte count and a read pointer through a small byte-wide register port. It sets the output-enable bit and then writes the trigger register. From that point the block offers one byte per pacing period on a valid/ready handshake. The pacing period is a base of four clocks per step multiplied by a runtime multiple input, so the default multiple of 6 gives 24 clocks per byte. The multiple can be changed while a transfer runs.

The count is held as two byte registers and is decremented after every accepted byte. The transfer completes when the count borrows below zero, so a programmed value of N moves N+1 bytes. Completion raises the busy flag (which is active low) and pulls the end flag low. The end flag stays low until software writes the acknowledge register. If the sink refuses an offered byte, the transfer is abandoned on the spot and the pointer and count keep their values.

The buffer is filled through a separate write port. Reads use the pointer masked to the buffer depth, so a transfer wraps around the end of the buffer.

Top module: `paced_dma_streamer`

## Requirements
- R1: A trigger write (select 5) while control bit 0 (output enable, select 4) is 0 has no effect: no byte is offered and the status byte does not change.
- R2: Status bit 0 is an active-low busy flag. A trigger that takes effect drives it to 0, and the completing byte drives it back to 1.
- R3: With count N (select 0 is the low byte, select 1 is the high byte), exactly N+1 bytes are accepted. The low byte decrements on each accepted byte, and the high byte decrements when the low byte wraps. The transfer ends when both wrap, leaving the count at 0xFFFF.
- R4: The spacing between two accepted bytes is 4 × M clocks, where M is the multiple input. A multiple of 0 acts as 1.
- R5: The first byte is offered in the clock cycle that directly follows the trigger write edge.
- R6: A change of the multiple during a transfer takes effect from the byte that follows the next accepted byte. The spacing already running is kept.
- R7: Byte k of a transfer carries buffer[(P + k) mod depth], where P is the 16-bit read pointer (select 2 is the low byte, select 3 is the high byte). The pointer increments by one per accepted byte.
- R8: An offered byte with ready low aborts the transfer. No further byte is offered, the pointer and count keep their values, and the busy flag stays 0.
- R9: Status bit 1 is an active-low end flag and end_irq is its inverse. Completion drives the flag to 0. A write to select 6 (acknowledge) drives it back to 1.
- R10: After reset the status byte is 0xFF, the count and pointer are 0, and no byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 to 6) |
| reg_wdata | input | 8 | Register write data |
| pace_mult | input | 4 | Pacing multiple |
| buf_we | input | 1 | Buffer write enable |
| buf_waddr | input | 11 | Buffer write address |
| buf_wdata | input | 8 | Buffer write data |
| snk_valid | output | 1 | Byte offered to the sink |
| snk_data | output | 8 | Offered byte |
| snk_ready | input | 1 | Sink accepts the offered byte |
| end_irq | output | 1 | End-of-transfer interrupt, active high |
| status | output | 8 | Status byte: bit 0 busy_n, bit 1 end_n, other bits 1 |
| count | output | 16 | Current byte count |
| rd_ptr | output | 16 | Current read pointer |

## Verification
The bench targets the following corner cases:
- **Count of zero.** This must still move one byte. A design that stops on reaching zero moves none.
- **Count of 0x0100.** This forces a borrow into the high byte. A design that decrements the high byte on the wrong wrap stops after one byte or runs far past 257.
- **Pointer crossing the top of the buffer, and a multiple of 0.** These expose a missing address mask and a zero-length period that would flood the sink.
- **Multiple changed right after the first byte.** This separates reload-time sampling from a design that rescales the gap already counting.
- **Ignored trigger and refused byte.** An ignored trigger catches a design that starts with output disabled. A refused byte catches one that stalls or still advances the pointer.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  typedef enum logic [2:0] {
    SEL_CNT_LO = 3'd0,
    SEL_CNT_HI = 3'd1,
    SEL_PTR_LO = 3'd2,
    SEL_PTR_HI = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_TRIG   = 3'd5,
    SEL_ACK    = 3'd6
  } reg_sel_e;

  localparam int ST_BUSY_N = 0;
  localparam int ST_END_N  = 1;
  localparam int CTRL_OUTEN = 0;

endpackage

// File: rtl/pdma_buf_ram.sv
module pdma_buf_ram #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pdma_byte_count.sv
module pdma_byte_count (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  wdata,
  input  logic        dec,
  output logic [15:0] count,
  output logic        borrow
);

  logic [7:0] lo_q, hi_q;

  // Low byte: a write wins over a decrement
  always_ff @(posedge clk) begin
    if (rst)        lo_q <= 8'h00;
    else if (wr_lo) lo_q <= wdata;
    else if (dec)   lo_q <= lo_q - 8'd1;
  end

  // High byte steps only when the low byte wraps
  always_ff @(posedge clk) begin
    if (rst)                        hi_q <= 8'h00;
    else if (wr_hi)                 hi_q <= wdata;
    else if (dec && lo_q == 8'h00)  hi_q <= hi_q - 8'd1;
  end

  assign count  = {hi_q, lo_q};
  assign borrow = dec && (lo_q == 8'h00) && (hi_q == 8'h00);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !wr_lo && !wr_hi) |=> count == $past(count) - 16'd1);

endmodule

// File: rtl/pdma_pacer.sv
module pdma_pacer #(
  parameter int MULT_W    = 4,
  parameter int STEP_CLKS = 4,
  localparam int PER_W    = $clog2(STEP_CLKS * ((1 << MULT_W) - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              accept,
  input  logic              refuse,
  input  logic              finish,
  input  logic [MULT_W-1:0] mult,
  output logic              offer
);

  logic             active_q;
  logic [PER_W-1:0] wait_q;
  logic [MULT_W-1:0] eff_mult;
  logic [PER_W-1:0] period;

  always_comb begin
    eff_mult = (mult == '0) ? MULT_W'(1) : mult;
    period   = PER_W'(STEP_CLKS) * PER_W'(eff_mult);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      wait_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      wait_q   <= '0;
    end else if (active_q) begin
      if (accept) begin
        if (finish) active_q <= 1'b0;
        else        wait_q   <= period - PER_W'(1);
      end else if (refuse) begin
        active_q <= 1'b0;
      end else if (wait_q != '0) begin
        wait_q <= wait_q - PER_W'(1);
      end
    end
  end

  assign offer = active_q && (wait_q == '0);

  // R4
  gap_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !start) |=> !offer);

  // R5
  first_offer_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> offer);

endmodule

// File: rtl/paced_dma_streamer.sv
module paced_dma_streamer
  import pdma_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int MULT_W    = 4,
  parameter int STEP_CLKS = 4,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic [MULT_W-1:0] pace_mult,
  input  logic              buf_we,
  input  logic [AW-1:0]     buf_waddr,
  input  logic [7:0]        buf_wdata,
  output logic              snk_valid,
  output logic [7:0]        snk_data,
  input  logic              snk_ready,
  output logic              end_irq,
  output logic [7:0]        status,
  output logic [15:0]       count,
  output logic [15:0]       rd_ptr
);

  logic        wr_cnt_lo, wr_cnt_hi, wr_ptr_lo, wr_ptr_hi, wr_ctrl, wr_trig, wr_ack;
  logic        offer, accept, refuse, start, borrow;
  logic        outen_q, busy_n_q, end_n_q;
  logic [15:0] ptr_q;

  always_comb begin
    wr_cnt_lo = reg_we && (reg_sel == SEL_CNT_LO);
    wr_cnt_hi = reg_we && (reg_sel == SEL_CNT_HI);
    wr_ptr_lo = reg_we && (reg_sel == SEL_PTR_LO);
    wr_ptr_hi = reg_we && (reg_sel == SEL_PTR_HI);
    wr_ctrl   = reg_we && (reg_sel == SEL_CTRL);
    wr_trig   = reg_we && (reg_sel == SEL_TRIG);
    wr_ack    = reg_we && (reg_sel == SEL_ACK);
  end

  assign start  = wr_trig && outen_q;
  assign accept = offer && snk_ready;
  assign refuse = offer && !snk_ready;

  pdma_buf_ram #(.DEPTH(DEPTH), .DW(8)) i_ram (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (ptr_q[AW-1:0]),
    .rdata (snk_data)
  );

  pdma_byte_count i_count (
    .clk    (clk),
    .rst    (rst),
    .wr_lo  (wr_cnt_lo),
    .wr_hi  (wr_cnt_hi),
    .wdata  (reg_wdata),
    .dec    (accept),
    .count  (count),
    .borrow (borrow)
  );

  pdma_pacer #(.MULT_W(MULT_W), .STEP_CLKS(STEP_CLKS)) i_pacer (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .accept (accept),
    .refuse (refuse),
    .finish (borrow),
    .mult   (pace_mult),
    .offer  (offer)
  );

  // Read pointer: register writes win over the per-byte increment
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= 16'h0000;
    end else begin
      if (wr_ptr_lo) ptr_q[7:0]  <= reg_wdata;
      if (wr_ptr_hi) ptr_q[15:8] <= reg_wdata;
      if (accept && !wr_ptr_lo && !wr_ptr_hi) ptr_q <= ptr_q + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          outen_q <= 1'b0;
    else if (wr_ctrl) outen_q <= reg_wdata[CTRL_OUTEN];
  end

  // Status flags, both active low
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_n_q <= 1'b1;
      end_n_q  <= 1'b1;
    end else begin
      if (start)                 busy_n_q <= 1'b0;
      else if (accept && borrow) busy_n_q <= 1'b1;
      if (accept && borrow)      end_n_q  <= 1'b0;
      else if (wr_ack)           end_n_q  <= 1'b1;
    end
  end

  always_comb begin
    status            = 8'hFF;
    status[ST_BUSY_N] = busy_n_q;
    status[ST_END_N]  = end_n_q;
  end

  assign snk_valid = offer;
  assign end_irq   = ~end_n_q;
  assign rd_ptr    = ptr_q;

  // R1
  idle_trigger_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_trig && !outen_q && status[ST_BUSY_N] && !snk_valid) |=> (!snk_valid && status[ST_BUSY_N]));

  // R2
  done_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (snk_valid && snk_ready && count == 16'h0000 && !reg_we) |=> (status[ST_BUSY_N] && end_irq));

  // R7
  ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (snk_valid && snk_ready && !reg_we) |=> rd_ptr == $past(rd_ptr) + 16'd1);

  // R8
  refuse_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (snk_valid && !snk_ready && !reg_we) |=> ($stable(rd_ptr) && $stable(count) && !snk_valid));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ack && !(accept && borrow)) |=> status[ST_END_N]);

endmodule

// File: tb/test_paced_dma_streamer.sv
`timescale 1ns/1ps
module test_paced_dma_streamer;

  localparam int DEPTH = 2048;
  localparam int MASK  = DEPTH - 1;
  localparam int NVEC  = 6;
  // {first multiple, multiple after first byte, count, pointer}
  localparam logic [39:0] VECS [NVEC] = '{
    {4'd6,  4'd6,  16'd3,     16'h0010},
    {4'd1,  4'd1,  16'd0,     16'h0005},
    {4'd0,  4'd0,  16'd2,     16'h07FE},
    {4'd15, 4'd15, 16'h0100,  16'h0100},
    {4'd1,  4'd3,  16'd3,     16'h0020},
    {4'd2,  4'd5,  16'd1,     16'h07FF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [3:0]  pace_mult = 4'd6;
  logic        buf_we = 1'b0;
  logic [10:0] buf_waddr = '0;
  logic [7:0]  buf_wdata = '0;
  logic        snk_valid;
  logic [7:0]  snk_data;
  logic        snk_ready = 1'b1;
  logic        end_irq;
  logic [7:0]  status;
  logic [15:0] count;
  logic [15:0] rd_ptr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  paced_dma_streamer i_paced_dma_streamer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pace_mult(pace_mult), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready), .end_irq(end_irq),
    .status(status), .count(count), .rd_ptr(rd_ptr)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 13) ^ (i >> 5));
  endfunction

  function automatic int cpb(input int m);
    return 4 * ((m == 0) ? 1 : m);
  endfunction

  // R11-style map as in R1/R3/R7/R9: 0/1 count, 2/3 pointer, 4 control, 5 trigger, 6 ack
  task automatic wr(input int sel, input int data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = 8'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_xfer(input int m0, input int m1, input int cnt, input int ptr);
    int n = 0, last = 0, t = 0;
    bit chg = 0;
    pace_mult = 4'(m0);
    snk_ready = 1'b1;
    wr(0, cnt & 255); wr(1, cnt >> 8);
    wr(2, ptr & 255); wr(3, ptr >> 8);
    wr(4, 1);
    wr(5, 0);
    check(snk_valid == 1'b1, "R5", "first offer after trigger", int'(snk_valid), 1);
    check(status[0] == 1'b0, "R2", "busy flag low while running", int'(status[0]), 0);
    while (t < 20000) begin
      if (n == 1 && !chg) begin pace_mult = 4'(m1); chg = 1; end
      if (snk_valid && snk_ready) begin
        check(snk_data == pat((ptr + n) & MASK), "R7", "byte data", int'(snk_data), int'(pat((ptr + n) & MASK)));
        if (n > 0)
          check((t - last) == ((n == 1) ? cpb(m0) : cpb(m1)), (m0 != m1) ? "R6" : "R4",
                "byte spacing", t - last, (n == 1) ? cpb(m0) : cpb(m1));
        last = t;
        n++;
      end
      if (status[0]) break;
      @(negedge clk);
      t++;
    end
    check(n == cnt + 1, "R3", "bytes moved", n, cnt + 1);
    check(count == 16'hFFFF, "R3", "count after end", int'(count), 16'hFFFF);
    check(rd_ptr == 16'(ptr + cnt + 1), "R7", "pointer after end", int'(rd_ptr), (ptr + cnt + 1) & 16'hFFFF);
    check(status == 8'hFD, "R2", "status at end", int'(status), 8'hFD);
    check(end_irq == 1'b1, "R9", "end interrupt raised", int'(end_irq), 1);
    wr(6, 0);
    check(status == 8'hFF, "R9", "status after ack", int'(status), 8'hFF);
    check(end_irq == 1'b0, "R9", "interrupt after ack", int'(end_irq), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(status == 8'hFF, "R10", "status after reset", int'(status), 8'hFF);
    check(snk_valid == 1'b0, "R10", "valid after reset", int'(snk_valid), 0);
    check(end_irq == 1'b0, "R10", "irq after reset", int'(end_irq), 0);
    check(count == 16'h0 && rd_ptr == 16'h0, "R10", "count/pointer after reset", int'(count), 0);

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_waddr = 11'(i); buf_wdata = pat(i);
    end
    @(negedge clk);
    buf_we = 1'b0;

    // R1: trigger with output disabled
    wr(5, 0);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      if (snk_valid) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R1", "offers after disabled trigger", seen, 0);
    check(status == 8'hFF, "R1", "status after disabled trigger", int'(status), 8'hFF);

    for (int v = 0; v < NVEC; v++)
      run_xfer(int'(VECS[v][39:36]), int'(VECS[v][35:32]), int'(VECS[v][31:16]), int'(VECS[v][15:0]));

    // R8: sink refuses the first byte
    pace_mult = 4'd6;
    wr(0, 5); wr(1, 0); wr(2, 8'h40); wr(3, 0);
    @(negedge clk);
    snk_ready = 1'b0;
    wr(5, 0);
    check(snk_valid == 1'b1, "R8", "byte offered before refusal", int'(snk_valid), 1);
    @(negedge clk);
    seen = 0;
    for (int k = 0; k < 100; k++) begin
      if (snk_valid) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R8", "offers after refusal", seen, 0);
    check(count == 16'd5, "R8", "count kept", int'(count), 5);
    check(rd_ptr == 16'h0040, "R8", "pointer kept", int'(rd_ptr), 16'h40);
    check(status == 8'hFE, "R8", "busy stays low", int'(status), 8'hFE);
    check(end_irq == 1'b0, "R8", "no end interrupt", int'(end_irq), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule